// File: doc/BRIEF.md
# Registered Bidirectional Bus Switch

This block links an A-side bus and a B-side bus through a set of independent byte-wide channels (two by default). Each channel has its own control set: an active-low output enable, a direction bit, and one capture clock and one source select for each direction. Each direction keeps a holding register. The A-side register samples the A port on a rising edge of that channel's A-to-B capture clock. The B-side register samples the B port on a rising edge of its B-to-A capture clock. Nothing gates these loads. They happen while the channel is isolated and while it drives either port. The block can therefore act as a bus-management switch: it can pass live data, replay a stored word, or record traffic without driving anything.

The pins are modelled as separate input, output and output-enable vectors, so the block needs no inout nets. Each channel is in one of three modes, chosen combinationally from its enable and direction:
- ISOLATE: the enable is high. No output is driven.
- DRIVE_A: the enable is low and the direction is low. The A port is driven.
- DRIVE_B: the enable is low and the direction is high. The B port is driven.

The mode changes with the control inputs alone, in the same cycle, and has no registered state. A driven port carries either the live word from the opposite port or the word held in the opposite side's register, depending on that direction's select. Channels can run independently, or with their controls tied together as one wide path.

Top module: `bus_switch_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears every holding register to zero. The registers stay zero while reset is low, even if capture clocks pulse.
- R2: On each rising edge of a channel's A-to-B capture clock, that channel's A-side register loads the channel's A-port input bits, whatever the enable, direction and select values.
- R3: On each rising edge of a channel's B-to-A capture clock, that channel's B-side register loads the channel's B-port input bits, whatever the enable, direction and select values.
- R4: When a channel's enable is 1 (ISOLATE), all of its A and B output-enable bits are 0 and its A and B output bits read 0. Registers keep their contents across isolation.
- R5: When a channel's enable is 0 and its direction is 0 (DRIVE_A), all of its A output-enable bits are 1, all of its B output-enable bits are 0, and its B output bits read 0.
- R6: When a channel's enable is 0 and its direction is 1 (DRIVE_B), all of its B output-enable bits are 1, all of its A output-enable bits are 0, and its A output bits read 0.
- R7: In DRIVE_A, the A output carries the live B-port input when the B-to-A select is 0, and the B-side register when that select is 1.
- R8: In DRIVE_B, the B output carries the live A-port input when the A-to-B select is 0, and the A-side register when that select is 1.
- R9: A channel never has an A output-enable bit and a B output-enable bit set at the same time.
- R10: Channel n occupies bits n*8 to n*8+7 of every port vector and responds only to its own control bits n.
- R11: Outputs and output enables follow their inputs combinationally, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of all holding registers |
| oe_n | input | N_CH | Per-channel active-low output enable |
| dir | input | N_CH | Per-channel direction: 0 drives A, 1 drives B |
| clk_ab | input | N_CH | Per-channel capture clock of the A-side register |
| clk_ba | input | N_CH | Per-channel capture clock of the B-side register |
| sel_ab | input | N_CH | Per-channel source for the B output: 0 live A, 1 stored A |
| sel_ba | input | N_CH | Per-channel source for the A output: 0 live B, 1 stored B |
| a_in | input | N_CH*CH_W | A-port pin inputs |
| a_out | output | N_CH*CH_W | A-port pin output values |
| a_oe | output | N_CH*CH_W | A-port pin drive enables |
| b_in | input | N_CH*CH_W | B-port pin inputs |
| b_out | output | N_CH*CH_W | B-port pin output values |
| b_oe | output | N_CH*CH_W | B-port pin drive enables |

## Verification
The bench records words while both ports are isolated, then moves the data inputs without clocking and enables replay. A design that gated capture on the enable would replay stale words, and one that lost state in isolation would replay garbage. It sweeps all sixteen enable, direction and select combinations, with a different combination on each channel, and clocks captures while a port is driven. This exposes swapped selects, inverted direction, drive leaking onto both sides, and control bits crossing between channels. It pulses capture clocks during reset and also drops reset in the middle of a run. A register that loaded under reset, or cleared only on a clock edge, would then show a nonzero stored word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Drive mode of one channel, decoded from enable and direction
    typedef enum logic [1:0] {
        XM_ISOLATE = 2'd0,
        XM_DRIVE_A = 2'd1,
        XM_DRIVE_B = 2'd2
    } xmode_e;

endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
    parameter int W = 8
) (
    input  logic         cap_clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Loads on every rising capture edge; no enable gating by design
    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/xcvr_port_route.sv
module xcvr_port_route
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] a_held,
    input  logic [W-1:0] b_held,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    xmode_e mode;

    // Mode decode: enable dominates, then direction
    always_comb begin
        if (oe_n)      mode = XM_ISOLATE;
        else if (dir)  mode = XM_DRIVE_B;
        else           mode = XM_DRIVE_A;
    end

    // Output process: only the selected side is driven
    always_comb begin
        a_out = '0;
        a_oe  = '0;
        b_out = '0;
        b_oe  = '0;
        unique case (mode)
            XM_ISOLATE: begin
            end
            XM_DRIVE_A: begin
                a_oe  = '1;
                a_out = sel_ba ? b_held : b_in;
            end
            XM_DRIVE_B: begin
                b_oe  = '1;
                b_out = sel_ab ? a_held : a_in;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bus_switch_xcvr.sv
module bus_switch_xcvr #(
    parameter int N_CH = 2,
    parameter int CH_W = 8,
    localparam int TOT_W = N_CH * CH_W
) (
    input  logic             rst_n,
    input  logic [N_CH-1:0]  oe_n,
    input  logic [N_CH-1:0]  dir,
    input  logic [N_CH-1:0]  clk_ab,
    input  logic [N_CH-1:0]  clk_ba,
    input  logic [N_CH-1:0]  sel_ab,
    input  logic [N_CH-1:0]  sel_ba,
    input  logic [TOT_W-1:0] a_in,
    output logic [TOT_W-1:0] a_out,
    output logic [TOT_W-1:0] a_oe,
    input  logic [TOT_W-1:0] b_in,
    output logic [TOT_W-1:0] b_out,
    output logic [TOT_W-1:0] b_oe
);

    logic [TOT_W-1:0] a_held_all;
    logic [TOT_W-1:0] b_held_all;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam int LO = ch * CH_W;

        xcvr_hold_reg #(.W(CH_W)) u_a_reg (
            .cap_clk (clk_ab[ch]),
            .rst_n   (rst_n),
            .d       (a_in[LO +: CH_W]),
            .q       (a_held_all[LO +: CH_W])
        );

        xcvr_hold_reg #(.W(CH_W)) u_b_reg (
            .cap_clk (clk_ba[ch]),
            .rst_n   (rst_n),
            .d       (b_in[LO +: CH_W]),
            .q       (b_held_all[LO +: CH_W])
        );

        xcvr_port_route #(.W(CH_W)) u_route (
            .oe_n   (oe_n[ch]),
            .dir    (dir[ch]),
            .sel_ab (sel_ab[ch]),
            .sel_ba (sel_ba[ch]),
            .a_in   (a_in[LO +: CH_W]),
            .b_in   (b_in[LO +: CH_W]),
            .a_held (a_held_all[LO +: CH_W]),
            .b_held (b_held_all[LO +: CH_W]),
            .a_out  (a_out[LO +: CH_W]),
            .a_oe   (a_oe[LO +: CH_W]),
            .b_out  (b_out[LO +: CH_W]),
            .b_oe   (b_oe[LO +: CH_W])
        );
    end

endmodule

// File: rtl/bus_switch_xcvr_chk.sv
module bus_switch_xcvr_chk #(
    parameter int N_CH = 2,
    parameter int CH_W = 8,
    localparam int TOT_W = N_CH * CH_W
) (
    input logic             rst_n,
    input logic [N_CH-1:0]  oe_n,
    input logic [N_CH-1:0]  dir,
    input logic [N_CH-1:0]  clk_ab,
    input logic [N_CH-1:0]  clk_ba,
    input logic [N_CH-1:0]  sel_ab,
    input logic [N_CH-1:0]  sel_ba,
    input logic [TOT_W-1:0] a_in,
    input logic [TOT_W-1:0] a_out,
    input logic [TOT_W-1:0] a_oe,
    input logic [TOT_W-1:0] b_in,
    input logic [TOT_W-1:0] b_out,
    input logic [TOT_W-1:0] b_oe,
    input logic [TOT_W-1:0] a_held_all,
    input logic [TOT_W-1:0] b_held_all
);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
        localparam int LO = ch * CH_W;

        p_capture_a_r2: assert property (@(posedge clk_ab[ch]) disable iff (!rst_n)
            1'b1 |=> a_held_all[LO +: CH_W] == $past(a_in[LO +: CH_W]));

        p_capture_b_r3: assert property (@(posedge clk_ba[ch]) disable iff (!rst_n)
            1'b1 |=> b_held_all[LO +: CH_W] == $past(b_in[LO +: CH_W]));

        p_isolate_r4: assert property (@(posedge clk_ab[ch]) disable iff (!rst_n)
            oe_n[ch] |-> (a_oe[LO +: CH_W] == '0 && b_oe[LO +: CH_W] == '0));

        p_drive_a_r5: assert property (@(posedge clk_ab[ch]) disable iff (!rst_n)
            (!oe_n[ch] && !dir[ch]) |-> (a_oe[LO +: CH_W] == '1 && b_oe[LO +: CH_W] == '0));

        p_drive_b_r6: assert property (@(posedge clk_ba[ch]) disable iff (!rst_n)
            (!oe_n[ch] && dir[ch]) |-> (b_oe[LO +: CH_W] == '1 && a_oe[LO +: CH_W] == '0));

        p_stored_to_a_r7: assert property (@(posedge clk_ba[ch]) disable iff (!rst_n)
            (!oe_n[ch] && !dir[ch] && sel_ba[ch]) |-> a_out[LO +: CH_W] == b_held_all[LO +: CH_W]);

        p_live_to_b_r8: assert property (@(posedge clk_ab[ch]) disable iff (!rst_n)
            (!oe_n[ch] && dir[ch] && !sel_ab[ch]) |-> b_out[LO +: CH_W] == a_in[LO +: CH_W]);

        p_one_side_r9: assert property (@(posedge clk_ba[ch]) disable iff (!rst_n)
            !((|a_oe[LO +: CH_W]) && (|b_oe[LO +: CH_W])));
    end

endmodule

bind bus_switch_xcvr bus_switch_xcvr_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
    .rst_n      (rst_n),
    .oe_n       (oe_n),
    .dir        (dir),
    .clk_ab     (clk_ab),
    .clk_ba     (clk_ba),
    .sel_ab     (sel_ab),
    .sel_ba     (sel_ba),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .a_held_all (a_held_all),
    .b_held_all (b_held_all)
);

// File: tb/bus_switch_xcvr_bench.sv
`timescale 1ns/1ps
module bus_switch_xcvr_bench;

    localparam int NC = 2;
    localparam int W  = 8;
    localparam int TW = NC * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NC-1:0] oe_n, dir, clk_ab, clk_ba, sel_ab, sel_ba;
    logic [TW-1:0] a_in, b_in;
    logic [TW-1:0] a_out, a_oe, b_out, b_oe;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    bit    cmp_on = 1'b0;
    string tag    = "R1";

    // Behavioural model of the held words, one per side and channel
    logic [W-1:0] m_a [NC];
    logic [W-1:0] m_b [NC];

    always #10 clk = ~clk;

    bus_switch_xcvr #(.N_CH(NC), .CH_W(W)) u_bus_switch_xcvr (
        .rst_n (rst_n), .oe_n (oe_n), .dir (dir),
        .clk_ab (clk_ab), .clk_ba (clk_ba),
        .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
    );

    task automatic check8(input int ch, input string what,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ch%0d %s actual %h expected %h", tag, ch, what, act, exp);
        end
    endtask

    // Compare every port slice against the model on each clock
    always @(posedge clk) begin
        if (cmp_on) begin
            for (int c = 0; c < NC; c++) begin
                logic [W-1:0] e_aoe, e_boe, e_aout, e_bout;
                e_aoe = '0; e_boe = '0; e_aout = '0; e_bout = '0;
                if (!rst_n) begin
                    m_a[c] = '0;
                    m_b[c] = '0;
                end
                if (!oe_n[c] && !dir[c]) begin
                    e_aoe  = '1;
                    e_aout = sel_ba[c] ? m_b[c] : b_in[c*W +: W];
                end
                if (!oe_n[c] && dir[c]) begin
                    e_boe  = '1;
                    e_bout = sel_ab[c] ? m_a[c] : a_in[c*W +: W];
                end
                check8(c, "a_oe",  a_oe[c*W +: W],  e_aoe);
                check8(c, "b_oe",  b_oe[c*W +: W],  e_boe);
                check8(c, "a_out", a_out[c*W +: W], e_aout);
                check8(c, "b_out", b_out[c*W +: W], e_bout);
                // R9: both sides never enabled together
                check8(c, "R9 overlap", {7'd0, (|a_oe[c*W +: W]) & (|b_oe[c*W +: W])}, 8'd0);
            end
        end
    end

    // Drive at the falling edge, then pulse the chosen capture clocks
    task automatic step(input logic [NC-1:0] ab, input logic [NC-1:0] ba,
                        input bit new_data);
        @(negedge clk);
        if (new_data) begin
            a_in = TW'($urandom);
            b_in = TW'($urandom);
        end
        #2;
        for (int c = 0; c < NC; c++) begin
            if (rst_n && ab[c]) m_a[c] = a_in[c*W +: W];
            if (rst_n && ba[c]) m_b[c] = b_in[c*W +: W];
        end
        clk_ab = ab;
        clk_ba = ba;
        #4;
        clk_ab = '0;
        clk_ba = '0;
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin m_a[c] = '0; m_b[c] = '0; end
        rst_n = 1'b0; clk_ab = '0; clk_ba = '0;
        oe_n = '0; dir = 2'b10; sel_ab = '1; sel_ba = '1;
        a_in = '0; b_in = '0;

        // R1: stored words read zero under reset despite capture pulses
        tag = "R1 reset";
        cmp_on = 1'b1;
        for (int i = 0; i < 3; i++) step(2'b11, 2'b11, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        step(2'b00, 2'b00, 1'b1);

        // R2 R3 R4: capture while isolated, outputs stay quiet
        tag = "R2 R3 R4 isolated capture";
        oe_n = 2'b11;
        for (int i = 0; i < 4; i++) step(2'b11, 2'b11, 1'b1);

        // R2 R3 retention: data moves without clocks, then replay
        tag = "R2 R3 retention";
        for (int i = 0; i < 3; i++) step(2'b00, 2'b00, 1'b1);
        oe_n = 2'b00; dir = 2'b00; sel_ba = 2'b11;
        step(2'b00, 2'b00, 1'b1);
        dir = 2'b11; sel_ab = 2'b11;
        step(2'b00, 2'b00, 1'b1);

        // R4 R5 R6 R7 R8 R10: every control combination, channels differ
        tag = "R4 R5 R6 R7 R8 R10 sweep";
        for (int k = 0; k < 16; k++) begin
            logic [3:0] k0, k1;
            k0 = 4'(k);
            k1 = 4'(15 - k);
            oe_n   = {k1[3], k0[3]};
            dir    = {k1[2], k0[2]};
            sel_ab = {k1[1], k0[1]};
            sel_ba = {k1[0], k0[0]};
            step(k0[1:0] ^ 2'b01, k1[1:0], 1'b1);
            step(2'b00, 2'b00, 1'b1);
        end

        // R9 R11: capture while driving; outputs follow the same cycle
        tag = "R9 R11 drive and capture";
        oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b11; sel_ba = 2'b11;
        for (int i = 0; i < 6; i++) step(2'b11, 2'b11, 1'b1);
        sel_ab = 2'b00; sel_ba = 2'b00;
        for (int i = 0; i < 4; i++) step(2'b10, 2'b01, 1'b1);

        // R1: asynchronous clear in mid-run, no clock edge needed
        tag = "R1 async reset";
        sel_ab = 2'b11; sel_ba = 2'b11;
        @(negedge clk); rst_n = 1'b0;
        step(2'b00, 2'b00, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        step(2'b00, 2'b00, 1'b0);

        @(negedge clk);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule